// File: doc/BRIEF.md
# Four-Phase Handshake Sequencer

This block is a clock-driven controller that sequences two handshakes behind one. A parent port (`p_req` in, `p_ack` out) is passive: an upstream master asks for service by raising `p_req`. Two child ports, first (`s1_req` out, `s1_ack` in) and second (`s2_req` out, `s2_ack` in), are active. Every port follows the four-phase, return-to-zero discipline on separate request and acknowledge wires. A request is raised, then held until the acknowledge rises. It is then lowered, and the port is idle again once the acknowledge falls.

For each parent request, the controller runs a complete first handshake, including its return to zero. It then raises the second request. When the second acknowledge arrives, the parent is acknowledged. The second port's release overlaps the parent's release: the controller drops `s2_req` only after `p_req` falls, and drops `p_ack` only after `s2_ack` falls.

All inputs are assumed to be synchronous to `clk`. Every output comes straight from a flip-flop, so each response appears exactly one clock edge after the input level that caused it was sampled.

The controller has six states, and each one maps to a fixed set of output levels:

| State | Output levels | Transition |
|---|---|---|
| IDLE | all low | to FIRST_RAISE on `p_req` |
| FIRST_RAISE | `s1_req` high | to FIRST_DROP on `s1_ack` |
| FIRST_DROP | all low | to SECOND_RAISE on `!s1_ack` |
| SECOND_RAISE | `s2_req` high | to PARENT_ACK on `s2_ack` |
| PARENT_ACK | `s2_req` and `p_ack` high | to SECOND_DROP on `!p_req` |
| SECOND_DROP | `p_ack` high | to IDLE on `!s2_ack` |

Top module: `hs_seq_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, that edge drives `p_ack`, `s1_req` and `s2_req` low, and the controller restarts from IDLE.
- R2: From IDLE, `s1_req` rises on the edge after the one where `p_req` is sampled high. No child request rises before the parent request has been seen.
- R3: `s1_req` stays high until `s1_ack` is sampled high, and falls on the edge after that.
- R4: `s2_req` rises only on the edge after `s1_ack` is sampled low following the fall of `s1_req`. `s1_req` and `s2_req` are never high together.
- R5: `p_ack` rises on the edge after `s2_ack` is sampled high, and `s2_req` stays high at that point.
- R6: `s2_req` stays high until `p_req` is sampled low while `p_ack` is high, and falls on the edge after that. `p_ack` stays high while this happens.
- R7: `p_ack` falls on the edge after `s2_ack` is sampled low following the fall of `s2_req`. A later `p_req` then starts a new cycle.
- R8: With `p_req` held low, all three outputs stay low indefinitely after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| p_req | input | 1 | Parent request from the upstream master |
| p_ack | output | 1 | Parent acknowledge |
| s1_req | output | 1 | First child request |
| s1_ack | input | 1 | First child acknowledge |
| s2_req | output | 1 | Second child request |
| s2_ack | input | 1 | Second child acknowledge |

## Verification
The bench goes after the following corner cases:
- A controller that raised the second request while `s1_ack` was still high would let the two children overlap. The bench provokes this by having the first responder release its acknowledge late.
- A controller that dropped `s2_req` before the parent released `p_req` would break the interleaved return-to-zero. The same happens if it dropped `p_ack` before `s2_ack` fell. Random parent release delays expose both faults.
- Acknowledges that arrive on the very edge after the request rose, as well as acknowledges held back for several cycles, show off-by-one sampling and premature state exits.
- An idle window with `p_req` held low catches a controller that leaves reset with a request already active.

// File: rtl/hs_seq_pkg.sv
package hs_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE         = 3'd0,
        ST_FIRST_RAISE  = 3'd1,
        ST_FIRST_DROP   = 3'd2,
        ST_SECOND_RAISE = 3'd3,
        ST_PARENT_ACK   = 3'd4,
        ST_SECOND_DROP  = 3'd5
    } seq_state_e;

endpackage

// File: rtl/hs_seq_fsm.sv
module hs_seq_fsm
    import hs_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       p_req,
    input  logic       s1_ack,
    input  logic       s2_ack,
    output seq_state_e state_nx
);

    seq_state_e state_q;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_nx;
    end

    always_comb begin
        state_nx = state_q;
        if (rst) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:         if (p_req)   state_nx = ST_FIRST_RAISE;
                ST_FIRST_RAISE:  if (s1_ack)  state_nx = ST_FIRST_DROP;
                ST_FIRST_DROP:   if (!s1_ack) state_nx = ST_SECOND_RAISE;
                ST_SECOND_RAISE: if (s2_ack)  state_nx = ST_PARENT_ACK;
                ST_PARENT_ACK:   if (!p_req)  state_nx = ST_SECOND_DROP;
                ST_SECOND_DROP:  if (!s2_ack) state_nx = ST_IDLE;
                default:                      state_nx = ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/hs_seq_outs.sv
module hs_seq_outs
    import hs_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  seq_state_e state_nx,
    output logic       p_ack,
    output logic       s1_req,
    output logic       s2_req
);

    logic p_ack_d, s1_req_d, s2_req_d;

    always_comb begin
        p_ack_d  = 1'b0;
        s1_req_d = 1'b0;
        s2_req_d = 1'b0;
        unique case (state_nx)
            ST_IDLE:         ;
            ST_FIRST_RAISE:  s1_req_d = 1'b1;
            ST_FIRST_DROP:   ;
            ST_SECOND_RAISE: s2_req_d = 1'b1;
            ST_PARENT_ACK: begin
                s2_req_d = 1'b1;
                p_ack_d  = 1'b1;
            end
            ST_SECOND_DROP:  p_ack_d = 1'b1;
            default:         ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            p_ack  <= 1'b0;
            s1_req <= 1'b0;
            s2_req <= 1'b0;
        end else begin
            p_ack  <= p_ack_d;
            s1_req <= s1_req_d;
            s2_req <= s2_req_d;
        end
    end

endmodule

// File: rtl/hs_seq_ctrl.sv
module hs_seq_ctrl
    import hs_seq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic p_req,
    output logic p_ack,
    output logic s1_req,
    input  logic s1_ack,
    output logic s2_req,
    input  logic s2_ack
);

    seq_state_e state_nx;

    hs_seq_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .p_req    (p_req),
        .s1_ack   (s1_ack),
        .s2_ack   (s2_ack),
        .state_nx (state_nx)
    );

    hs_seq_outs u_outs (
        .clk      (clk),
        .rst      (rst),
        .state_nx (state_nx),
        .p_ack    (p_ack),
        .s1_req   (s1_req),
        .s2_req   (s2_req)
    );

    // R1
    reset_low_chk: assert property (@(posedge clk)
        $past(rst) |-> (!p_ack && !s1_req && !s2_req));

    // R2
    first_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(s1_req) |-> $past(p_req));

    // R3
    first_release_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(s1_req) |-> $past(s1_ack));

    // R4
    second_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(s2_req) |-> $past(!s1_ack));

    // R4
    no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
        !(s1_req && s2_req));

    // R5
    parent_ack_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(p_ack) |-> ($past(s2_ack) && s2_req));

    // R6
    second_release_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(s2_req) |-> ($past(!p_req) && p_ack));

    // R7
    parent_release_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(p_ack) |-> ($past(!s2_ack) && !s2_req));

endmodule

// File: tb/hs_seq_ctrl_test.sv
module hs_seq_ctrl_test;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic p_req = 1'b0;
    logic s1_ack = 1'b0;
    logic s2_ack = 1'b0;
    logic p_ack, s1_req, s2_req;

    int checks = 0;
    int errors = 0;
    int done_cycles = 0;

    always #5 clk = ~clk;

    hs_seq_ctrl uut (
        .clk    (clk),
        .rst    (rst),
        .p_req  (p_req),
        .p_ack  (p_ack),
        .s1_req (s1_req),
        .s1_ack (s1_ack),
        .s2_req (s2_req),
        .s2_ack (s2_ack)
    );

    // Reference model: the expected position in the event list of one
    // transaction. Values 0..5 stand for idle, first up, first down,
    // second up, parent acknowledged, second down.
    int  step = 0;
    bit  e_p = 0, e_s1 = 0, e_s2 = 0;
    bit  env_on = 0;
    int  p_cnt = 0, c1_cnt = 0, c2_cnt = 0;

    task automatic check_bit(input string tag, input bit act, input bit exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at %0t: actual %0b expected %0b", tag, $time, act, exp);
        end
    endtask

    task automatic model_step(input bit pr, input bit a1, input bit a2);
        case (step)
            0: if (pr)  begin e_s1 = 1; step = 1; end
            1: if (a1)  begin e_s1 = 0; step = 2; end
            2: if (!a1) begin e_s2 = 1; step = 3; end
            3: if (a2)  begin e_p  = 1; step = 4; end
            4: if (!pr) begin e_s2 = 0; step = 5; end
            5: if (!a2) begin e_p  = 0; step = 0; done_cycles++; end
            default: step = 0;
        endcase
    endtask

    task automatic compare_all;
        check_bit(e_s1 ? "R2 s1_req" : "R3 s1_req", s1_req, e_s1);
        check_bit(e_s2 ? "R4 s2_req" : "R6 s2_req", s2_req, e_s2);
        check_bit(e_p  ? "R5 p_ack"  : "R7 p_ack",  p_ack,  e_p);
        check_bit("R4 overlap", s1_req && s2_req, 1'b0);
    endtask

    task automatic drive_env;
        if (!env_on) return;
        // Active parent environment
        if ((!p_req && !p_ack) || (p_req && p_ack)) begin
            if (p_cnt == 0) begin
                p_req = ~p_req;
                p_cnt = $urandom_range(0, 4);
            end else p_cnt--;
        end
        // Passive responders with random latency
        if (s1_ack != s1_req) begin
            if (c1_cnt == 0) begin
                s1_ack = s1_req;
                c1_cnt = $urandom_range(0, 5);
            end else c1_cnt--;
        end
        if (s2_ack != s2_req) begin
            if (c2_cnt == 0) begin
                s2_ack = s2_req;
                c2_cnt = $urandom_range(0, 5);
            end else c2_cnt--;
        end
    endtask

    task automatic run_cycles(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            if (rst) begin
                step = 0; e_p = 0; e_s1 = 0; e_s2 = 0;
            end else begin
                model_step(p_req, s1_ack, s2_ack);
            end
            #1;
            compare_all();
            @(negedge clk);
            drive_env();
        end
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(7));
        run_cycles(3);
        // R1: outputs low while held in reset
        check_bit("R1 p_ack", p_ack, 1'b0);
        check_bit("R1 s1_req", s1_req, 1'b0);
        check_bit("R1 s2_req", s2_req, 1'b0);
        @(negedge clk);
        rst = 1'b0;
        // R8: no spontaneous activity with passive inputs low
        run_cycles(25);
        check_bit("R8 idle outputs", p_ack | s1_req | s2_req, 1'b0);
        // Randomised traffic
        env_on = 1;
        run_cycles(4000);
        // Reset in mid-transaction, then more traffic
        env_on = 0;
        rst = 1'b1;
        run_cycles(2);
        check_bit("R1 mid reset", p_ack | s1_req | s2_req, 1'b0);
        p_req = 0; s1_ack = 0; s2_ack = 0;
        p_cnt = 0; c1_cnt = 0; c2_cnt = 0;
        @(negedge clk);
        rst = 1'b0;
        run_cycles(10);
        check_bit("R8 idle after reset", p_ack | s1_req | s2_req, 1'b0);
        env_on = 1;
        run_cycles(2000);
        checks++;
        if (done_cycles < 100) begin
            errors++;
            $display("FAIL R7 completed transactions: actual %0d expected >= 100", done_cycles);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule